// File: doc/BRIEF.md
# Reloading Rate Generator Timer

A down-counting timer that emits a repeating pulse exactly one clock wide. A host writes a reload value into a count register and then writes an 8-bit control word. When the gate input is at its programmed active level, the counter steps down once per clock from the reload value to zero. At zero it raises the pulse output for that one cycle and reloads on the next edge. The idle time between two pulses therefore equals the programmed count.

A count written while the timer runs is stored as pending. It is used at the next reload, not earlier. A control write with the jam bit set forces the pending value into the counter at once. Each pulse also sets an interrupt flag. The flag holds until it is acknowledged or the control register is written again.

The controller has three states:
- IDLE: stopped.
- WAIT: armed, waiting for the gate.
- RUN: counting.

Its transitions are:
- start: IDLE to RUN, on a valid control write while the gate is active.
- arm: IDLE to WAIT, on a valid control write while the gate is inactive.
- gate-go: WAIT to RUN, when the gate becomes active.
- disarm: RUN to WAIT, on a valid control write while the gate is inactive.
- stop: any state to IDLE, on a control write that selects another mode.
- Within RUN the controller takes one of three actions each cycle: tick (decrement), reload (at zero) or jam (forced load).

Top module: `rate_gen_timer`

## Requirements
- R1: After synchronous reset, `pulse_o` and `irq_o` are 0 and the timer stays stopped. Count register writes alone start nothing.
- R2: A control write is valid when bits [2:0] equal 3'b100, whatever bits [7:5] hold. Any other value in bits [2:0] stops the timer (IDLE) and suppresses pulses.
- R3: Control bit 3 sets the gate polarity: 1 means active high, 0 means active low. While the gate is inactive in RUN, the count holds and no pulse is emitted.
- R4: In RUN with the gate active, the count steps N, N-1, ..., 0 and then reloads. `pulse_o` is high only in the cycle the count is 0, so N idle cycles separate pulses.
- R5: A valid control write made while the gate is active (judged by the newly written polarity) loads the count register on that edge. The first pulse appears N+1 cycles after the write.
- R6: A valid control write made while the gate is inactive arms the timer (WAIT). The gate going active then loads the count and starts RUN. The first cycle after that start is not specified.
- R7: A count register write during RUN does not change the current countdown. The new value is used at the next reload.
- R8: A valid control write with bit 4 (jam) set, made during RUN, loads the pending count immediately. Without bit 4, the countdown continues undisturbed.
- R9: `irq_o` rises the cycle after a pulse. It stays high until `int_ack` is pulsed or a control write occurs. A pulse in the same cycle as an acknowledge still sets it.
- R10: With a count of 0, `pulse_o` is high on every cycle the gate is active in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_din | input | 8 | Control word: [2:0] mode, [3] gate polarity, [4] jam |
| cnt_we | input | 1 | Count register write strobe |
| cnt_din | input | CNT_W | Reload value |
| gate_in | input | 1 | Gate input |
| int_ack | input | 1 | Interrupt acknowledge pulse |
| pulse_o | output | 1 | One-clock terminal-count pulse |
| irq_o | output | 1 | Interrupt flag |

## Verification
Each fault in the internal state shows at the ports within one pulse period:
- A corrupted count, or a reload that takes the wrong value, moves the next pulse earlier or later.
- A wrong state (for example, stuck in WAIT or falsely in RUN) makes pulses vanish or appear while the timer should be quiet.
- A lost interrupt flag shows on `irq_o` one cycle after the pulse.

The bench therefore runs an independent model every clock and compares both outputs. The only cycle it skips is the unspecified one after a gate-triggered start.

// File: rtl/rgt_pkg.sv
package rgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } rgt_state_e;

    localparam int          MODE_W    = 3;
    localparam logic [2:0]  MODE_RATE = 3'b100;
    localparam int          POL_BIT   = 3;
    localparam int          JAM_BIT   = 4;
endpackage

// File: rtl/rgt_ctrl_regs.sv
module rgt_ctrl_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_din,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_din,
    input  logic             gate_in,
    output logic [CNT_W-1:0] reload_val,
    output logic             wr_mode_ok,
    output logic             wr_gate_ok,
    output logic             wr_jam,
    output logic             gate_act
);
    import rgt_pkg::*;

    logic             pol_q;
    logic [CNT_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q  <= 1'b1;
            pend_q <= '0;
        end else begin
            if (ctrl_we) pol_q  <= ctrl_din[POL_BIT];
            if (cnt_we)  pend_q <= cnt_din;
        end
    end

    // Decode of the word being written this cycle
    assign wr_mode_ok = (ctrl_din[MODE_W-1:0] == MODE_RATE);
    assign wr_gate_ok = (gate_in == ctrl_din[POL_BIT]);
    assign wr_jam     = ctrl_din[JAM_BIT];
    assign gate_act   = (gate_in == pol_q);
    assign reload_val = pend_q;
endmodule

// File: rtl/rgt_down_counter.sv
module rgt_down_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tc
);
    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (dec)    cnt <= cnt - 1'b1;
    end

    assign tc = (cnt == '0);

    // R4
    dec_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (dec && !load && !clr) |-> !tc);
endmodule

// File: rtl/rgt_fsm.sv
module rgt_fsm (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_we,
    input  logic wr_mode_ok,
    input  logic wr_gate_ok,
    input  logic wr_jam,
    input  logic gate_act,
    input  logic tc,
    output logic ld,
    output logic dec,
    output logic clr,
    output logic running,
    output logic idle
);
    import rgt_pkg::*;

    rgt_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        ld  = 1'b0;
        dec = 1'b0;
        clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ctrl_we && wr_mode_ok) begin
                    if (wr_gate_ok) begin nxt = ST_RUN; ld = 1'b1; end  // start
                    else            nxt = ST_WAIT;                      // arm
                end
            end
            ST_WAIT: begin
                if (ctrl_we) begin
                    if (!wr_mode_ok)     begin nxt = ST_IDLE; clr = 1'b1; end  // stop
                    else if (wr_gate_ok) begin nxt = ST_RUN;  ld  = 1'b1; end  // start
                end else if (gate_act) begin
                    nxt = ST_RUN; ld = 1'b1;                                   // gate-go
                end
            end
            ST_RUN: begin
                if (ctrl_we && !wr_mode_ok) begin
                    nxt = ST_IDLE; clr = 1'b1;                 // stop
                end else if (ctrl_we && !wr_gate_ok) begin
                    nxt = ST_WAIT;                             // disarm
                end else if (ctrl_we && wr_jam) begin
                    ld = 1'b1;                                 // jam
                end else if (ctrl_we || gate_act) begin
                    if (tc) ld  = 1'b1;                        // reload
                    else    dec = 1'b1;                        // tick
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign running = (state == ST_RUN);
    assign idle    = (state == ST_IDLE);

    // R2
    bad_mode_stops_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && !wr_mode_ok) |=> idle);
endmodule

// File: rtl/rate_gen_timer.sv
module rate_gen_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic [7:0]       ctrl_din,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_din,
    input  logic             gate_in,
    input  logic             int_ack,
    output logic             pulse_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] reload_val, cnt;
    logic wr_mode_ok, wr_gate_ok, wr_jam, gate_act;
    logic ld, dec, clr, running, idle, tc;

    rgt_ctrl_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_din(ctrl_din),
        .cnt_we(cnt_we), .cnt_din(cnt_din), .gate_in(gate_in),
        .reload_val(reload_val), .wr_mode_ok(wr_mode_ok),
        .wr_gate_ok(wr_gate_ok), .wr_jam(wr_jam), .gate_act(gate_act)
    );

    rgt_fsm u_fsm (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .wr_mode_ok(wr_mode_ok),
        .wr_gate_ok(wr_gate_ok), .wr_jam(wr_jam), .gate_act(gate_act),
        .tc(tc), .ld(ld), .dec(dec), .clr(clr),
        .running(running), .idle(idle)
    );

    rgt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .load(ld), .dec(dec),
        .load_val(reload_val), .cnt(cnt), .tc(tc)
    );

    assign pulse_o = running && gate_act && tc;

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= pulse_o || (irq_o && !int_ack && !ctrl_we);
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        idle |-> !pulse_o);
    // R3
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (running && !gate_act && !ctrl_we) |=> $stable(cnt));
    // R4
    pulse_one_wide_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && !ctrl_we && reload_val != '0) |=> !pulse_o);
    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> irq_o);
    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !int_ack && !ctrl_we) |=> irq_o);
endmodule

// File: tb/sim_rate_gen_timer.sv
module sim_rate_gen_timer;
    localparam int CLK_P = 10;
    localparam int CNT_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_we = 1'b0;
    logic [7:0] ctrl_din = 8'h00;
    logic cnt_we = 1'b0;
    logic [CNT_W-1:0] cnt_din = '0;
    logic gate_in = 1'b1;
    logic int_ack = 1'b0;
    logic pulse_o, irq_o;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    rate_gen_timer #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_din(ctrl_din),
        .cnt_we(cnt_we), .cnt_din(cnt_din), .gate_in(gate_in),
        .int_ack(int_ack), .pulse_o(pulse_o), .irq_o(irq_o)
    );

    // Behavioural model: 0 stopped, 1 armed, 2 counting
    int m_st = 0;
    int m_cnt = 0;
    int m_pend = 0;
    bit m_pol = 1;
    bit m_irq = 0;
    bit skip = 0;

    function automatic bit exp_pulse();
        return (m_st == 2) && (gate_in == m_pol) && (m_cnt == 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_pend = 0; m_pol = 1; m_irq = 0; skip = 1;
        end else begin
            bit p, mok, wok, jam, gact;
            int old_pend;
            p = exp_pulse();
            mok = (ctrl_din[2:0] == 3'b100);
            wok = (gate_in == ctrl_din[3]);
            jam = ctrl_din[4];
            gact = (gate_in == m_pol);
            old_pend = m_pend;
            m_irq = p || (m_irq && !int_ack && !ctrl_we);
            if (ctrl_we && !mok) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                if (ctrl_we) begin
                    if (wok) begin m_st = 2; m_cnt = old_pend; end
                    else m_st = 1;
                end
            end else if (m_st == 1) begin
                if (ctrl_we) begin
                    if (wok) begin m_st = 2; m_cnt = old_pend; end
                end else if (gact) begin
                    m_st = 2; m_cnt = old_pend; skip = 1;
                end
            end else begin
                if (ctrl_we && !wok) m_st = 1;
                else if (ctrl_we && jam) m_cnt = old_pend;
                else if (ctrl_we || gact) begin
                    if (m_cnt == 0) m_cnt = old_pend;
                    else m_cnt = m_cnt - 1;
                end
            end
            if (ctrl_we) m_pol = ctrl_din[3];
            if (cnt_we) m_pend = int'(cnt_din);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (skip) skip = 0;
            else begin
                total++;
                if (pulse_o !== exp_pulse()) begin
                    bad++;
                    $display("FAIL %s pulse_o actual=%0b expected=%0b t=%0t",
                             cur_req, pulse_o, exp_pulse(), $time);
                end
                total++;
                if (irq_o !== m_irq) begin
                    bad++;
                    $display("FAIL %s irq_o actual=%0b expected=%0b t=%0t",
                             cur_req, irq_o, m_irq, $time);
                end
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            ctrl_we = 1'b0; cnt_we = 1'b0; int_ack = 1'b0;
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        @(posedge clk); #1;
        cnt_we = 1'b0; int_ack = 1'b0;
        ctrl_we = 1'b1; ctrl_din = v;
    endtask

    task automatic wr_cnt(input int v);
        @(posedge clk); #1;
        ctrl_we = 1'b0; int_ack = 1'b0;
        cnt_we = 1'b1; cnt_din = CNT_W'(v);
    endtask

    task automatic ack();
        @(posedge clk); #1;
        ctrl_we = 1'b0; cnt_we = 1'b0;
        int_ack = 1'b1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, count write alone does not start
        cur_req = "R1";
        step(3);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        total++;
        if (pulse_o !== 1'b0 || irq_o !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset outputs actual=%0b%0b expected=00", pulse_o, irq_o);
        end
        wr_cnt(3); step(6);

        // R5 / R4: software start with active-high gate, count 3
        cur_req = "R5";
        wr_ctrl(8'b0000_1100); step(1);
        cur_req = "R4";
        step(12);

        // R7: deferred count while running
        cur_req = "R7";
        wr_cnt(5); step(16);

        // R8: jam forces immediate load; without jam it continues
        cur_req = "R8";
        step(2); wr_cnt(2); step(1);
        wr_ctrl(8'b0001_1100); step(9);
        wr_cnt(6); step(1);
        wr_ctrl(8'b0000_1100); step(12);

        // R3: gate inactive holds count; then active-low polarity
        cur_req = "R3";
        gate_in = 1'b0; step(5);
        gate_in = 1'b1; step(6);
        wr_ctrl(8'b0000_0100); gate_in = 1'b0; step(1);
        step(9);
        gate_in = 1'b1; step(4);
        gate_in = 1'b0; step(10);

        // R9: acknowledge, and set beating ack in same cycle
        cur_req = "R9";
        ack(); step(3);
        wr_cnt(0); step(1);
        wr_ctrl(8'b0001_0100); step(1);
        ack(); step(1); ack(); step(2);
        wr_cnt(4); step(1);
        wr_ctrl(8'b0001_0100); step(2);
        ack(); step(8);

        // R10: count 0 pulses every active cycle
        cur_req = "R10";
        wr_cnt(0); step(1);
        wr_ctrl(8'b0001_1100); gate_in = 1'b1; step(1);
        step(6);
        gate_in = 1'b0; step(2);
        gate_in = 1'b1; step(3);

        // R6: armed by write with gate inactive, started by gate
        cur_req = "R6";
        wr_cnt(2); step(1);
        gate_in = 1'b0;
        wr_ctrl(8'b0000_1100); step(5);
        gate_in = 1'b1; step(12);

        // R2: upper bits ignored; other mode stops the timer
        cur_req = "R2";
        wr_cnt(3); step(1);
        wr_ctrl(8'b1110_1100); step(10);
        wr_ctrl(8'b0000_1101); step(8);
        wr_ctrl(8'b0000_1000); step(6);

        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule